// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter Slice

This block is a presettable binary counter slice with a parameterised width (four bits by default). It changes state on the rising clock edge. In each cycle it either holds its value, loads a parallel word, or steps one count up or down. Two active-low count enables must both be low for a step to happen. An active-low synchronous load takes priority over counting. A direction input selects up (high) or down (low).

An active-low ripple-carry output flags the terminal state for the current direction, gated by the second enable. Slices are cascaded by tying each slice's carry output to both count enables of the next, more significant slice, with every slice on the same clock. The chain then behaves as one wider synchronous counter with no extra gating.

The state register uses an asynchronous active-low reset. The reset is expected to be released synchronously by the surrounding reset tree.

Top module: `sync_updn_cnt`

## Requirements
- R1: While rst_ni is low, q_o is all zeros. The reset overrides load and count.
- R2: With load_ni high, both enables low and up_i high, q_o increases by one at the next rising edge.
- R3: With load_ni high, both enables low and up_i low, q_o decreases by one at the next rising edge.
- R4: With load_ni high and either en_p_ni or en_t_ni high, q_o keeps its value across the edge.
- R5: With load_ni low, q_o equals din_i after the next rising edge, whatever the enable levels. When both enables are also low, no step occurs.
- R6: Counting wraps. All ones steps up to all zeros, and all zeros steps down to all ones.
- R7: carry_no is combinational and active low. It is low exactly when en_t_ni is low and q_o is at the terminal state: all ones when up_i is high, all zeros when up_i is low. en_p_ni has no effect on it.
- R8: Two slices share a clock, and the low slice's carry_no drives both enables of the high slice. The pair then counts, loads, holds and wraps as one 8-bit counter in both directions. The low slice holds bits 3:0 and the high slice holds bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| load_ni | input | 1 | Active-low synchronous parallel load |
| en_p_ni | input | 1 | Active-low count enable (count gating only) |
| en_t_ni | input | 1 | Active-low count enable that also gates carry_no |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| din_i | input | WIDTH | Parallel load data |
| q_o | output | WIDTH | Counter state |
| carry_no | output | 1 | Active-low terminal-count carry |

## Verification
The count outputs are due one rising edge after the control levels are presented, because one register lies between them. carry_no is due in the same cycle, since it decodes the current state, en_t_ni and up_i with no register. The bench changes inputs shortly after the falling edge and advances its reference model on the rising edge. It compares both slices' states and both carries at the following falling edge, where the register outputs and the combinational carries have settled. A cascade case with en_p_ni high, en_t_ni low and the low slice at its terminal state checks that the high slice still steps.

// File: rtl/sync_updn_cnt_pkg.sv
package sync_updn_cnt_pkg;

  typedef enum logic [1:0] {
    CNT_OP_HOLD = 2'd0,
    CNT_OP_LOAD = 2'd1,
    CNT_OP_STEP = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/updn_op_decode.sv
module updn_op_decode
  import sync_updn_cnt_pkg::*;
(
  input  logic    load_ni,
  input  logic    en_p_ni,
  input  logic    en_t_ni,
  output cnt_op_e op_o
);

  // Load wins over counting; counting needs both enables asserted (low).
  always_comb begin
    if (!load_ni) begin
      op_o = CNT_OP_LOAD;
    end else if (!en_p_ni && !en_t_ni) begin
      op_o = CNT_OP_STEP;
    end else begin
      op_o = CNT_OP_HOLD;
    end
  end

endmodule

// File: rtl/updn_step.sv
module updn_step #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] q_step_o
);

  // Look-ahead toggle chain: a bit flips when every lower bit is at the
  // direction's terminal level (1 when counting up, 0 when counting down).
  logic [WIDTH-1:0] toggle;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    if (gi == 0) begin : g_lsb
      assign toggle[gi] = 1'b1;
    end else begin : g_upper
      assign toggle[gi] = toggle[gi-1] & (up_i ? q_i[gi-1] : ~q_i[gi-1]);
    end
    assign q_step_o[gi] = q_i[gi] ^ toggle[gi];
  end

endmodule

// File: rtl/updn_term_detect.sv
module updn_term_detect #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_i,
  input  logic             en_t_ni,
  output logic             carry_no
);

  logic at_top;
  logic at_bottom;
  logic at_term;

  always_comb begin
    at_top    = &q_i;
    at_bottom = ~|q_i;
    at_term   = up_i ? at_top : at_bottom;
    carry_no  = ~(at_term & ~en_t_ni);
  end

endmodule

// File: rtl/sync_updn_cnt.sv
module sync_updn_cnt
  import sync_updn_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             en_p_ni,
  input  logic             en_t_ni,
  input  logic             up_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_no
);

  cnt_op_e          op;
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_d;
  logic [WIDTH-1:0] q_stepped;
  logic             q_en;

  updn_op_decode u_op_decode (
    .load_ni (load_ni),
    .en_p_ni (en_p_ni),
    .en_t_ni (en_t_ni),
    .op_o    (op)
  );

  updn_step #(.WIDTH(WIDTH)) u_step (
    .q_i      (q_q),
    .up_i     (up_i),
    .q_step_o (q_stepped)
  );

  updn_term_detect #(.WIDTH(WIDTH)) u_term (
    .q_i      (q_q),
    .up_i     (up_i),
    .en_t_ni  (en_t_ni),
    .carry_no (carry_no)
  );

  // Next state and clock enable.
  always_comb begin
    q_en = 1'b0;
    q_d  = q_q;
    unique case (op)
      CNT_OP_LOAD: begin
        q_en = 1'b1;
        q_d  = din_i;
      end
      CNT_OP_STEP: begin
        q_en = 1'b1;
        q_d  = q_stepped;
      end
      default: begin
        q_en = 1'b0;
        q_d  = q_q;
      end
    endcase
  end

  // State register.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/sync_updn_cnt_chk.sv
module sync_updn_cnt_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic             en_p_ni,
  input logic             en_t_ni,
  input logic             up_i,
  input logic [WIDTH-1:0] din_i,
  input logic [WIDTH-1:0] q_o,
  input logic             carry_no
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};

  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_p_ni && !en_t_ni && up_i) |=> (q_o == WIDTH'($past(q_o) + ONE))); // R2

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_p_ni && !en_t_ni && !up_i) |=> (q_o == WIDTH'($past(q_o) - ONE))); // R3

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && (en_p_ni || en_t_ni)) |=> $stable(q_o)); // R4

  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (q_o == $past(din_i))); // R5

  AST_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_p_ni && !en_t_ni && up_i && (q_o == ALL1)) |=> (q_o == '0)); // R6

  AST_WRAP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_p_ni && !en_t_ni && !up_i && (q_o == '0)) |=> (q_o == ALL1)); // R6

  AST_CARRY_NEEDS_T: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> !en_t_ni); // R7

  AST_CARRY_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (up_i ? (q_o == ALL1) : (q_o == '0))); // R7

  AST_CARRY_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_t_ni && (up_i ? (q_o == ALL1) : (q_o == '0))) |-> !carry_no); // R7

endmodule

bind sync_updn_cnt sync_updn_cnt_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_sync_updn_cnt.sv
module test_sync_updn_cnt;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_n;
  logic       en_p_n;
  logic       en_t_n;
  logic       up;
  logic [7:0] din;
  logic [3:0] q_lo;
  logic [3:0] q_hi;
  logic       c_lo_n;
  logic       c_hi_n;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // Reference model state (behavioural, per nibble).
  int    m_lo = 0;
  int    m_hi = 0;
  string tag_lo = "R1";
  string tag_hi = "R1";

  always #2.5 clk = ~clk;  // 200 MHz

  sync_updn_cnt #(.WIDTH(4)) i_sync_updn_cnt (
    .clk_i (clk), .rst_ni (rst_n), .load_ni (load_n),
    .en_p_ni (en_p_n), .en_t_ni (en_t_n), .up_i (up),
    .din_i (din[3:0]), .q_o (q_lo), .carry_no (c_lo_n)
  );

  sync_updn_cnt #(.WIDTH(4)) i_sync_updn_cnt_hi (
    .clk_i (clk), .rst_ni (rst_n), .load_ni (load_n),
    .en_p_ni (c_lo_n), .en_t_ni (c_lo_n), .up_i (up),
    .din_i (din[7:4]), .q_o (q_hi), .carry_no (c_hi_n)
  );

  function automatic bit at_term(int v, logic dir);
    return dir ? (v == 15) : (v == 0);
  endfunction

  function automatic int step(int v, logic dir);
    return dir ? ((v + 1) % 16) : ((v + 15) % 16);
  endfunction

  // Model advances on the rising edge using the levels present there.
  always @(posedge clk) begin
    bit lo_c;
    lo_c = !en_t_n && at_term(m_lo, up);
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; tag_lo = "R1"; tag_hi = "R1";
    end else begin
      tag_hi = "R8";
      if (!load_n) begin
        m_lo = int'(din[3:0]); m_hi = int'(din[7:4]); tag_lo = "R5";
      end else begin
        if (en_p_n || en_t_n) tag_lo = "R4";
        else if (at_term(m_lo, up)) tag_lo = "R6";
        else tag_lo = up ? "R2" : "R3";
        if (!en_p_n && !en_t_n) m_lo = step(m_lo, up);
        if (lo_c) m_hi = step(m_hi, up);
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      bit exp_lo_c;
      bit exp_hi_c;
      exp_lo_c = !en_t_n && at_term(m_lo, up);
      exp_hi_c = exp_lo_c && at_term(m_hi, up);
      check(tag_lo, "q_lo", int'(q_lo), m_lo);
      check(tag_hi, "q_hi", int'(q_hi), m_hi);
      check("R7", "carry_lo_n", int'(c_lo_n), int'(!exp_lo_c));
      check("R8", "carry_hi_n", int'(c_hi_n), int'(!exp_hi_c));
    end
  end

  task automatic apply(logic ld, logic p, logic t, logic u, logic [7:0] d, int n);
    load_n = ld; en_p_n = p; en_t_n = t; up = u; din = d;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; load_n = 1'b1; en_p_n = 1'b1; en_t_n = 1'b1; up = 1'b1; din = 8'h00;
    repeat (3) @(negedge clk);            // R1 reset checks
    #1; rst_n = 1'b1;
    apply(0, 1, 1, 1, 8'hFC, 1);          // R5 load with enables high
    apply(1, 0, 0, 1, 8'h00, 6);          // R2, R6, R7, R8: FC..02
    apply(1, 0, 0, 0, 8'h00, 5);          // R3, R6: 02..FD
    apply(1, 1, 0, 0, 8'h00, 3);          // R4 hold via P
    apply(1, 0, 1, 1, 8'h00, 3);          // R4 hold via T
    apply(0, 0, 0, 1, 8'h3F, 1);          // R5 load beats count
    apply(1, 0, 0, 1, 8'h00, 2);          // R8 3F -> 40 -> 41
    apply(0, 1, 1, 0, 8'h10, 1);
    apply(1, 0, 0, 0, 8'h00, 2);          // R8 10 -> 0F -> 0E
    apply(0, 1, 1, 1, 8'h0F, 1);
    apply(1, 1, 0, 1, 8'h00, 2);          // R7 carry ignores P; high slice steps
    apply(0, 1, 1, 1, 8'hF0, 1);
    apply(1, 0, 1, 0, 8'h00, 2);          // R7 carry gated by T at zero-nibble
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[3:0] == 4'h0, lfsr[4] & lfsr[5], lfsr[6] & lfsr[7] & lfsr[8],
            (i / 37) % 2 == 0, lfsr[15:8], 1);
    end
    rst_n = 1'b0;                         // R1 reset mid-run
    @(negedge clk);
    #1;
    finish_run();
  end

endmodule